// File: doc/BRIEF.md
# Multiplexed LCD Drive Sequencer

This block produces the digital level codes that steer the analog drivers of a three-common, one-third-duty multiplexed liquid-crystal panel. A frame counter advances on an oscillator clock enable and walks through three common phases. Each phase is split into a positive half and a negative half, so that the net DC across every pixel is zero. From the current phase and polarity, the block derives a two-bit level code for every common line and every segment line. The codes are 00 for ground, 01 for one-third of supply, 10 for two-thirds and 11 for full supply.

The display bitmap and the control settings come in through a one-cycle parallel load strobe, which stands in for a serial loader. The settings are the bias choice, power saving, forcing all segments off, and the port mode and port data of the first eight segment lines. An active-low inhibit input blanks the whole panel. Loads are still accepted while the panel is blanked, and the new contents show as soon as inhibit rises.

Top module: `lcd_mux_drive`

## Requirements
- R1: After reset the counter is at the start of the first phase, all loaded settings are zero (half bias, no power save, no forced off, no ports), and the bitmap is blank. With inhibit high, common 0 outputs 11, commons 1 and 2 output 01, and every segment outputs 01.
- R2: The counter advances once per clock cycle in which `osc_en` is high and power saving is off. A frame is 384 such steps. Common k is selected during steps 128k to 128k+127. Within each phase, the first 64 steps are the positive half and the next 64 are the negative half.
- R3: In third bias, the selected common outputs 11 in the positive half and 00 in the negative half. An unselected common outputs 01 in the positive half and 10 in the negative half.
- R4: In third bias, a lit segment outputs 00 in the positive half and 11 in the negative half. An unlit segment outputs 10 in the positive half and 01 in the negative half. Segment s is lit during phase c when bitmap bit c*35+s is set.
- R5: In half bias (bias bit 0), every common or segment code that would be 01 or 10 is output as 01 instead.
- R6: With all-segments-off set, every segment line outputs the unlit waveform whatever the bitmap holds, while the commons keep scanning.
- R7: With power saving set, the counter holds its position and every output is 00. Scanning resumes from the held position when power saving is cleared.
- R8: When port-mode bit i (i below 8) is set, segment line i outputs 11 if port-data bit i is 1 and 00 otherwise. This output does not change with phase, polarity or all-segments-off.
- R9: While `inh_n` is low, every common and segment output, port lines included, is 00 in the same cycle. The counter keeps running.
- R10: Loads made while `inh_n` is low are stored, and they appear on the outputs once `inh_n` returns high.
- R11: Values presented with `ld_en` high take effect on the outputs in the following cycle, including when the load coincides with a counter step or with the frame wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | Oscillator tick; one counter step per high cycle |
| ld_en | input | 1 | Parallel load strobe for bitmap and settings |
| ld_map | input | 105 | Bitmap; bit c*35+s lights segment s during phase c |
| ld_bias3 | input | 1 | 1 selects third bias, 0 selects half bias |
| ld_psave | input | 1 | Power-saving mode |
| ld_segoff | input | 1 | Force every segment to the unlit waveform |
| ld_pmode | input | 8 | Per-line port-mode enables for segment lines 0 to 7 |
| ld_pdata | input | 8 | Static port levels for segment lines 0 to 7 |
| inh_n | input | 1 | Active-low display inhibit |
| com_lvl | output | 6 | Level code per common, common k at bits 2k+1:2k |
| seg_lvl | output | 70 | Level code per segment, segment s at bits 2s+1:2s |

## Verification
The overlaps that matter are a load strobe landing in the same cycle as a counter step, and in particular on the frame wrap from step 383 to 0. A second overlap is a load made while inhibit holds the panel dark. The bench waits until its own step count reads 383 with the oscillator tick high, and fires the load strobe in that same cycle. In a separate pass it reloads the bitmap and settings while inhibit is low and then raises inhibit. Each cycle, the outputs are compared against a behavioural model that applies the counter step with the previous settings and then latches the new ones. Any mistake in ordering, or a lost load, shows up on the very next output sample.

// File: rtl/lcd_mux_drive.sv
module lcd_mux_drive #(
  parameter int NSEG  = 35,
  parameter int NCOM  = 3,
  parameter int NPORT = 8,
  parameter int HALF  = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   osc_en,
  input  logic                   ld_en,
  input  logic [NSEG*NCOM-1:0]   ld_map,
  input  logic                   ld_bias3,
  input  logic                   ld_psave,
  input  logic                   ld_segoff,
  input  logic [NPORT-1:0]       ld_pmode,
  input  logic [NPORT-1:0]       ld_pdata,
  input  logic                   inh_n,
  output logic [2*NCOM-1:0]      com_lvl,
  output logic [2*NSEG-1:0]      seg_lvl
);
  localparam int SW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int PW = (NCOM > 1) ? $clog2(NCOM) : 1;

  logic [NSEG*NCOM-1:0] map_q;
  logic                 bias3_q, psave_q, segoff_q;
  logic [NPORT-1:0]     pmode_q, pdata_q;
  logic [SW-1:0]        sub_q;
  logic                 neg_q;
  logic [PW-1:0]        ph_q;

  wire step    = osc_en && !psave_q;
  wire sub_end = (sub_q == SW'(HALF - 1));
  wire blank   = !inh_n || psave_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q    <= '0;
      bias3_q  <= 1'b0;
      psave_q  <= 1'b0;
      segoff_q <= 1'b0;
      pmode_q  <= '0;
      pdata_q  <= '0;
    end else if (ld_en) begin
      map_q    <= ld_map;
      bias3_q  <= ld_bias3;
      psave_q  <= ld_psave;
      segoff_q <= ld_segoff;
      pmode_q  <= ld_pmode;
      pdata_q  <= ld_pdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q <= '0;
      neg_q <= 1'b0;
      ph_q  <= '0;
    end else if (step) begin
      sub_q <= sub_end ? '0 : sub_q + 1'b1;
      if (sub_end) begin
        neg_q <= !neg_q;
        if (neg_q) ph_q <= (ph_q == PW'(NCOM - 1)) ? '0 : ph_q + 1'b1;
      end
    end
  end

  function automatic logic [1:0] fold(input logic [1:0] c, input logic b3);
    return (!b3 && (c[0] ^ c[1])) ? 2'b01 : c;
  endfunction

  logic [NSEG-1:0] row;
  always_comb begin
    row = '0;
    for (int c = 0; c < NCOM; c++)
      if (ph_q == PW'(c)) row = map_q[c*NSEG +: NSEG];
  end

  for (genvar c = 0; c < NCOM; c++) begin : g_com
    logic [1:0] raw;
    assign raw = (ph_q == PW'(c)) ? (neg_q ? 2'b00 : 2'b11)
                                  : (neg_q ? 2'b10 : 2'b01);
    assign com_lvl[2*c +: 2] = blank ? 2'b00 : fold(raw, bias3_q);
  end

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic       lit;
    logic [1:0] wav;
    assign lit = row[s] && !segoff_q;
    assign wav = lit ? (neg_q ? 2'b11 : 2'b00) : (neg_q ? 2'b01 : 2'b10);
    if (s < NPORT) begin : g_port
      assign seg_lvl[2*s +: 2] = blank ? 2'b00 :
        pmode_q[s] ? {2{pdata_q[s]}} : fold(wav, bias3_q);
    end else begin : g_plain
      assign seg_lvl[2*s +: 2] = blank ? 2'b00 : fold(wav, bias3_q);
    end
  end

  logic [NCOM-1:0] com_hi;
  logic            any_two3;
  always_comb begin
    any_two3 = 1'b0;
    for (int c = 0; c < NCOM; c++) begin
      com_hi[c] = (com_lvl[2*c +: 2] == 2'b11);
      if (com_lvl[2*c +: 2] == 2'b10) any_two3 = 1'b1;
    end
    for (int s = 0; s < NSEG; s++)
      if (seg_lvl[2*s +: 2] == 2'b10) any_two3 = 1'b1;
  end

  p_one_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (inh_n && !psave_q && !neg_q) |-> ($countones(com_hi) == 1));

  p_no_two3_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !bias3_q |-> !any_two3);

  p_inh_dark_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !inh_n |-> (com_lvl == '0 && seg_lvl == '0));

  p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    psave_q |=> ($stable(sub_q) && $stable(neg_q) && $stable(ph_q)));

  p_port_static_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pmode_q[0] && $past(pmode_q[0]) && $stable(pdata_q) && inh_n && $past(inh_n)
     && !psave_q && !$past(psave_q)) |-> $stable(seg_lvl[1:0]));
endmodule

// File: tb/sim_lcd_mux_drive.sv
module sim_lcd_mux_drive;
  localparam int NS = 35, NC = 3, NP = 8, FR = 384;

  logic clk = 0, rst_n = 0, osc_en = 0, ld_en = 0;
  logic [NS*NC-1:0] ld_map = '0;
  logic ld_bias3 = 0, ld_psave = 0, ld_segoff = 0;
  logic [NP-1:0] ld_pmode = '0, ld_pdata = '0;
  logic inh_n = 1;
  logic [2*NC-1:0] com_lvl;
  logic [2*NS-1:0] seg_lvl;

  lcd_mux_drive u0 (.clk, .rst_n, .osc_en, .ld_en, .ld_map, .ld_bias3, .ld_psave,
    .ld_segoff, .ld_pmode, .ld_pdata, .inh_n, .com_lvl, .seg_lvl);

  always #10 clk = ~clk;

  int errors = 0, checks = 0;
  string req = "R1";
  int oscmode = 0;
  int tick = 0;

  int cnt = 0;
  logic [NS*NC-1:0] m_map = '0;
  logic m_b3 = 0, m_ps = 0, m_so = 0;
  logic [NP-1:0] m_pm = '0, m_pd = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      cnt = 0; m_map = '0; m_b3 = 0; m_ps = 0; m_so = 0; m_pm = '0; m_pd = '0;
    end else begin
      if (osc_en && !m_ps) cnt = (cnt + 1) % FR;
      if (ld_en) begin
        m_map = ld_map; m_b3 = ld_bias3; m_ps = ld_psave; m_so = ld_segoff;
        m_pm = ld_pmode; m_pd = ld_pdata;
      end
    end
  end

  function automatic logic [1:0] fold(input logic [1:0] c, input logic b3);
    if (!b3 && (c == 2'b01 || c == 2'b10)) return 2'b01;
    return c;
  endfunction

  task automatic expect_now(output logic [2*NC-1:0] ec, output logic [2*NS-1:0] es);
    int ph = cnt / 128;
    int ng = (cnt / 64) % 2;
    logic dark = !inh_n || m_ps;
    for (int c = 0; c < NC; c++) begin
      logic [1:0] v = (c == ph) ? (ng ? 2'b00 : 2'b11) : (ng ? 2'b10 : 2'b01);
      ec[2*c +: 2] = dark ? 2'b00 : fold(v, m_b3);
    end
    for (int s = 0; s < NS; s++) begin
      logic [1:0] v;
      if (s < NP && m_pm[s]) v = m_pd[s] ? 2'b11 : 2'b00;
      else if (m_map[ph*NS + s] && !m_so) v = fold(ng ? 2'b11 : 2'b00, m_b3);
      else v = fold(ng ? 2'b01 : 2'b10, m_b3);
      es[2*s +: 2] = dark ? 2'b00 : v;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      logic [2*NC-1:0] ec;
      logic [2*NS-1:0] es;
      expect_now(ec, es);
      checks++;
      if (com_lvl !== ec || seg_lvl !== es) begin
        errors++;
        $display("FAIL %s step=%0d com=%h exp=%h seg=%h exp=%h", req, cnt, com_lvl, ec, seg_lvl, es);
      end
    end
  end

  task automatic chk(input string r, input logic ok, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic run(input int n);
    repeat (n) begin
      @(posedge clk); #2;
      tick++;
      osc_en = (oscmode == 0) ? 1'b1 : (tick % 3 == 0);
    end
  endtask

  task automatic load(input logic [NS*NC-1:0] mp, input logic b3, ps, so,
                      input logic [NP-1:0] pm, pd);
    @(posedge clk); #2;
    ld_en = 1; ld_map = mp; ld_bias3 = b3; ld_psave = ps; ld_segoff = so;
    ld_pmode = pm; ld_pdata = pd;
    @(posedge clk); #2;
    ld_en = 0;
  endtask

  function automatic logic [NS*NC-1:0] rnd_map();
    logic [NS*NC-1:0] m;
    for (int i = 0; i < NS*NC; i++) m[i] = $urandom_range(0, 1);
    return m;
  endfunction

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [NS*NC-1:0] mapa;
    int hi;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    // R1 reset levels
    chk("R1", com_lvl == 6'b010111, 128'(com_lvl), 128'(6'b010111));
    chk("R1", seg_lvl == {NS{2'b01}}, 128'(seg_lvl), 128'({NS{2'b01}}));

    req = "R3";
    mapa = rnd_map();
    load(mapa, 1, 0, 0, '0, '0);
    req = "R4";
    run(FR + 20);
    // R2 frame length: common 0 selected-high for 64 of 384 steps
    req = "R2";
    hi = 0;
    for (int i = 0; i < FR; i++) begin
      run(1);
      @(negedge clk);
      if (com_lvl[1:0] == 2'b11) hi++;
    end
    chk("R2", hi == 64, 128'(hi), 128'(64));
    oscmode = 1;
    run(FR * 2);
    oscmode = 0;

    req = "R5";
    load(rnd_map(), 0, 0, 0, '0, '0);
    run(FR + 10);

    req = "R6";
    load({NS*NC{1'b1}}, 1, 0, 1, '0, '0);
    run(200);
    @(negedge clk);
    chk("R6", seg_lvl[1:0] != 2'b00 && seg_lvl[1:0] != 2'b11, 128'(seg_lvl[1:0]), 128'(2'b10));

    req = "R7";
    load(mapa, 1, 1, 0, '0, '0);
    run(150);
    @(negedge clk);
    chk("R7", com_lvl == '0 && seg_lvl == '0, 128'(com_lvl), 128'(0));
    load(mapa, 1, 0, 0, '0, '0);
    run(100);

    req = "R8";
    load(mapa, 1, 0, 1, 8'hFF, 8'hA5);
    run(300);
    @(negedge clk);
    chk("R8", seg_lvl[15:0] == 16'hCC33, 128'(seg_lvl[15:0]), 128'(16'hCC33));
    load(mapa, 0, 0, 0, 8'h3C, 8'h0F);
    run(200);

    req = "R9";
    @(posedge clk); #2 inh_n = 0;
    run(50);
    @(negedge clk);
    chk("R9", com_lvl == '0 && seg_lvl == '0, 128'(seg_lvl), 128'(0));
    req = "R10";
    load(rnd_map(), 1, 0, 0, 8'h01, 8'h01);
    run(20);
    @(posedge clk); #2 inh_n = 1;
    @(negedge clk);
    chk("R10", seg_lvl[1:0] == 2'b11, 128'(seg_lvl[1:0]), 128'(2'b11));
    run(100);

    req = "R11";
    for (int k = 0; k < 2; k++) begin
      while (cnt != FR - 1) run(1);
      ld_en = 1; ld_map = rnd_map(); ld_bias3 = k[0]; ld_psave = 0; ld_segoff = 0;
      ld_pmode = 8'h80; ld_pdata = 8'h80;
      run(1);
      ld_en = 0;
      @(negedge clk);
      chk("R11", seg_lvl[15:14] == 2'b11 && cnt == 0, 128'(seg_lvl[15:14]), 128'(2'b11));
      run(50);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule